// File: doc/BRIEF.md
# Processor Hot-Alert Relay with Echo Hold-Off

This block links a processor's active-low thermal alert output to a shared open-drain alert wire. The same block also returns alerts from other agents on that wire to the processor's force-alert input. When the processor raises its alert, the block asks the pad to pull the shared wire low. When another agent drives the wire low while the processor is quiet, the block passes that low to the force output, so the processor throttles as well.

The difficulty is echo. The processor's own alert reaches the shared wire, and the wire then feeds the force output. The block therefore closes the return path in the same clock in which it samples the processor alert low. This happens before the wire low can come back through the synchronizer. After the processor releases its alert, the path stays closed for a fixed hold-off time. That time covers a shared wire that rises slowly through its pull-up. Releases of the wire by outside agents reach the force output with no added delay beyond the synchronizer.

The hold-off is set in clock cycles. By default it is derived from the clock period: it is the number of cycles nearest to 205 ns, which is 41 cycles at 5 ns.

Top module: `alert_relay`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released with idle inputs, `line_pull_en` is 0 and `force_n` is 1.
- R2: `line_pull_en` is 1 in the cycle after `proc_alert_n` is sampled 0. It is 0 in the cycle after `proc_alert_n` is sampled 1.
- R3: With `proc_alert_n` high and the path open, a 0 on `line_in` reaches `force_n` as a 0 three clock edges after the edge at which it is first sampled. Two of those edges are the synchronizer stages and one is the output register.
- R4: When `line_in` returns to 1 with the path open, `force_n` returns to 1 with the same three-edge latency, and no hold-off is added.
- R5: In the cycle after `proc_alert_n` is sampled 0, `force_n` is 1, even if the synchronized line is low.
- R6: After `proc_alert_n` is first sampled 1 following a low, the return path stays closed for HOLD_CYCLES edges. Here HOLD_CYCLES is the cycle count nearest to 205 ns, which is 41 at a 5 ns period. If `line_in` is still low at that point, `force_n` first falls one cycle after those edges.
- R7: A shared wire that stays low for up to 100 ns after the pull is released causes no 0 on `force_n`.
- R8: If `proc_alert_n` is sampled 0 again during the hold-off, the count restarts. The full hold-off is then timed from the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_alert_n | input | 1 | Processor hot alert, active low |
| line_in | input | 1 | Sampled level of the shared open-drain alert wire |
| line_pull_en | output | 1 | 1 asks the pad to pull the shared wire low; 0 releases it |
| force_n | output | 1 | Force-alert to the processor, active low |

## Verification
The bench models the shared wire with a slow recovery. A design without the hold-off, or with too short a hold-off, would show a brief low on `force_n` after a local alert is released. Three further checks target specific faults:
- The exact cycle at which the path reopens is checked, which catches a hold-off counter that is off by one.
- The local alert is raised while an outside agent already holds the wire low. A gate that used only the delayed, registered alert would let the wire low through for a cycle.
- The local alert is re-asserted partway through the hold-off. A design that failed to restart its count would reopen the path too early.

// File: rtl/alert_relay_pkg.sv
package alert_relay_pkg;
  // Round a time in picoseconds to the nearest whole number of clock cycles.
  function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                               input int unsigned clk_ps);
    return (t_ps + clk_ps / 2) / clk_ps;
  endfunction
endpackage

// File: rtl/alert_line_sync.sv
module alert_line_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{IDLE}};
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/alert_holdoff_timer.sv
module alert_holdoff_timer #(
  parameter int HOLD_CYCLES = 41
) (
  input  logic clk,
  input  logic rst,
  input  logic alert_n,
  output logic blocked
);
  localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt;

  // A low alert closes the path and clears the count. Each high sample
  // while the path is closed advances the count. The path reopens after
  // HOLD_CYCLES high samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      blocked <= 1'b0;
      cnt     <= '0;
    end else if (!alert_n) begin
      blocked <= 1'b1;
      cnt     <= '0;
    end else if (blocked) begin
      if (cnt == LAST) begin
        blocked <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/alert_force_gate.sv
module alert_force_gate (
  input  logic clk,
  input  logic rst,
  input  logic alert_n,
  input  logic blocked,
  input  logic line_low_s,
  output logic force_n,
  output logic pull_en
);
  logic path_open;

  // The live alert input gates the path directly. The return path is
  // therefore shut in the same edge that first sees the alert low.
  assign path_open = alert_n & ~blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      force_n <= 1'b1;
      pull_en <= 1'b0;
    end else begin
      force_n <= ~(line_low_s & path_open);
      pull_en <= ~alert_n;
    end
  end
endmodule

// File: rtl/alert_relay.sv
module alert_relay
  import alert_relay_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned HOLDOFF_PS    = 205000,
  parameter int          SYNC_STAGES   = 2,
  parameter int          HOLD_CYCLES   = int'(ps_to_cycles(HOLDOFF_PS, CLK_PERIOD_PS))
) (
  input  logic clk,
  input  logic rst,
  input  logic proc_alert_n,
  input  logic line_in,
  output logic line_pull_en,
  output logic force_n
);
  logic line_s;
  logic blocked;

  alert_line_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_in),
    .q   (line_s)
  );

  alert_holdoff_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .alert_n (proc_alert_n),
    .blocked (blocked)
  );

  alert_force_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .alert_n    (proc_alert_n),
    .blocked    (blocked),
    .line_low_s (~line_s),
    .force_n    (force_n),
    .pull_en    (line_pull_en)
  );
endmodule

// File: rtl/alert_relay_chk.sv
module alert_relay_chk (
  input logic clk,
  input logic rst,
  input logic proc_alert_n,
  input logic line_pull_en,
  input logic force_n
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!line_pull_en && force_n));

  // R2
  pull_assert_chk: assert property (@(posedge clk) disable iff (rst)
    !proc_alert_n |=> line_pull_en);

  // R2
  pull_release_chk: assert property (@(posedge clk) disable iff (rst)
    proc_alert_n |=> !line_pull_en);

  // R5
  echo_block_chk: assert property (@(posedge clk) disable iff (rst)
    !proc_alert_n |=> force_n);

  // R6
  holdoff_start_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_alert_n && !$past(proc_alert_n)) |=> force_n);

  // R3
  force_source_chk: assert property (@(posedge clk) disable iff (rst)
    (!force_n && !$past(rst)) |-> $past(proc_alert_n));
endmodule

bind alert_relay alert_relay_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .proc_alert_n (proc_alert_n),
  .line_pull_en (line_pull_en),
  .force_n      (force_n)
);

// File: tb/alert_relay_test.sv
module alert_relay_test;
  localparam int HOLD = 41; // nearest cycles to 205 ns at 5 ns

  typedef struct {
    int    cyc;
    logic  exp_force;
    bit    chk_pull;
    logic  exp_pull;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic proc_alert_n = 1'b1;
  logic ext_low = 1'b0;
  int   rise_len = 20;
  int   rise_left = 0;
  int   cyc = 0;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;
  logic line_pull_en, force_n, line_in;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  // Wire model: pulled low by the block or an outside agent; slow recovery
  // after the block lets go.
  always @(negedge clk) begin
    if (line_pull_en) rise_left <= rise_len;
    else if (rise_left > 0) rise_left <= rise_left - 1;
  end
  assign line_in = ~(ext_low | line_pull_en | (rise_left > 0));

  alert_relay uut (
    .clk          (clk),
    .rst          (rst),
    .proc_alert_n (proc_alert_n),
    .line_in      (line_in),
    .line_pull_en (line_pull_en),
    .force_n      (force_n)
  );

  task automatic expect_at(int c, logic f, bit cp, logic p, string tag);
    exp_t e;
    e.cyc = c; e.exp_force = f; e.chk_pull = cp; e.exp_pull = p; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected items in the cycle they are due.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.cyc != cyc) begin
        errors++;
        $display("FAIL %s missed cycle actual=%0d expected=%0d", e.tag, cyc, e.cyc);
      end else if (force_n !== e.exp_force) begin
        errors++;
        $display("FAIL %s cyc=%0d force_n actual=%b expected=%b", e.tag, cyc, force_n, e.exp_force);
      end else if (e.chk_pull && line_pull_en !== e.exp_pull) begin
        errors++;
        $display("FAIL %s cyc=%0d line_pull_en actual=%b expected=%b", e.tag, cyc, line_pull_en, e.exp_pull);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    int n;
    int m;
    int m2;
    wait_cyc(3);
    @(negedge clk);
    // R1: reset state, while in reset and on the first cycle after release
    checks++;
    if (force_n !== 1'b1 || line_pull_en !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset force_n=%b pull=%b expected=1/0", force_n, line_pull_en);
    end
    rst = 1'b0;
    n = cyc;
    expect_at(n + 1, 1'b1, 1, 1'b0, "R1");
    wait_cyc(5);

    // External alert forwarded (R3) and released (R4)
    @(negedge clk); ext_low = 1'b1; n = cyc;
    expect_at(n + 1, 1'b1, 1, 1'b0, "R2");
    expect_at(n + 2, 1'b1, 0, 1'b0, "R3");
    expect_at(n + 3, 1'b0, 0, 1'b0, "R3");
    wait_cyc(10);
    @(negedge clk); ext_low = 1'b0; m = cyc;
    expect_at(m + 2, 1'b0, 0, 1'b0, "R4");
    expect_at(m + 3, 1'b1, 0, 1'b0, "R4");
    wait_cyc(10);

    // Local alert while an outside agent holds the wire low (R5)
    @(negedge clk); ext_low = 1'b1; n = cyc;
    expect_at(n + 3, 1'b0, 0, 1'b0, "R3");
    wait_cyc(5);
    @(negedge clk); proc_alert_n = 1'b0; n = cyc;
    expect_at(n + 1, 1'b1, 1, 1'b1, "R5");
    expect_at(n + 4, 1'b1, 0, 1'b0, "R5");
    wait_cyc(6);
    @(negedge clk); ext_low = 1'b0;
    wait_cyc(4);
    @(negedge clk); proc_alert_n = 1'b1;
    wait_cyc(120);

    // Slow recovery within 100 ns: no glitch (R7)
    rise_len = 20;
    @(negedge clk); proc_alert_n = 1'b0; n = cyc;
    expect_at(n + 1, 1'b1, 1, 1'b1, "R2");
    wait_cyc(10);
    @(negedge clk); proc_alert_n = 1'b1; m = cyc;
    expect_at(m + 1, 1'b1, 1, 1'b0, "R2");
    for (int k = 2; k <= HOLD + 30; k++) expect_at(m + k, 1'b1, 0, 1'b0, "R7");
    wait_cyc(HOLD + 60);

    // Exact reopening of the path with a very slow wire (R6)
    rise_len = 60;
    @(negedge clk); proc_alert_n = 1'b0;
    wait_cyc(8);
    @(negedge clk); proc_alert_n = 1'b1; m = cyc;
    expect_at(m + HOLD, 1'b1, 0, 1'b0, "R6");
    expect_at(m + HOLD + 1, 1'b0, 0, 1'b0, "R6");
    expect_at(m + 80, 1'b1, 0, 1'b0, "R4");
    wait_cyc(100);

    // Re-assert during the hold-off restarts the count (R8)
    @(negedge clk); proc_alert_n = 1'b0;
    wait_cyc(8);
    @(negedge clk); proc_alert_n = 1'b1; m = cyc;
    wait_cyc(19);
    @(negedge clk); proc_alert_n = 1'b0; n = cyc;
    expect_at(n + 1, 1'b1, 1, 1'b1, "R8");
    wait_cyc(4);
    @(negedge clk); proc_alert_n = 1'b1; m2 = cyc;
    expect_at(m + HOLD + 1, 1'b1, 0, 1'b0, "R8");
    expect_at(m2 + HOLD, 1'b1, 0, 1'b0, "R8");
    expect_at(m2 + HOLD + 1, 1'b0, 0, 1'b0, "R8");
    wait_cyc(110);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule